// File: doc/BRIEF.md
# Two-Beat Bus Request Encoder

This block turns a processor memory or I/O request into the request phase of a shared bus transaction. A request is offered with a one-cycle `req_valid` pulse carrying a 36-bit physical address, a transaction kind, a caching type, a length code and an 8-bit byte-enable mask. The block checks the combination. A legal request is captured and held until the bus grant input is seen. An illegal one is refused with a one-cycle error pulse.

Once granted, the block drives two packets on the same address and request pins in back-to-back cycles. The first packet carries the 8-byte-aligned address and the kind, and the address strobe marks it. The second packet carries the caching type, the effective length and the effective byte enables. For write-back requests the length and byte enables are forced to a full line. For the other types the caller's length and mask pass through unchanged. Outside these two cycles the pins rest at zero.

Top module: `bus_req_encoder`

## Requirements
- R1: After reset, `bus_addr` and `bus_req` are zero and `bus_strobe`, `bus_busy`, `req_done` and `req_err` are low.
- R2: In packet A, `bus_strobe` is high for exactly one cycle. `bus_addr` equals `req_addr[35:3]`. `bus_req` equals {3'b000, kind}, with kind 00 = memory read, 01 = memory write, 10 = I/O read and 11 = I/O write.
- R3: Packet B is driven in the cycle right after packet A, with `req_done` high and `bus_strobe` low. `bus_addr[2:0]` holds the caching type, `bus_addr[10:3]` holds the effective byte enables and the upper bits are zero. `bus_req` is {3'b000, effective length}.
- R4: A write-back request (caching type 6) has an effective length of 11 (64-byte line) and effective byte enables of 8'hFF, whatever mask was supplied.
- R5: Uncacheable (0), write-combining (1), write-through (4) and write-protect (5) requests pass the supplied length code (00 = up to 8 bytes, 01 = 16 bytes, 11 = 64 bytes) and byte-enable mask through unchanged.
- R6: For I/O kinds, packet A carries only `req_addr[15:3]` as a port number, and every higher `bus_addr` bit is zero.
- R7: No packet starts before `bus_grant` is sampled high. Packet A appears in the cycle after the first clock edge at which the grant is high while a request is pending.
- R8: A write-back request with a length other than 11, or a caching type of 2, 3 or 7, raises `req_err` for one cycle, in the cycle after `req_valid`. No packet is produced.
- R9: `bus_busy` is high in the packet A and packet B cycles only. While it is low, the bus pins are zero.
- R10: A `req_valid` pulse that arrives while a request is pending is ignored. The packets carry the request that was captured first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request offer |
| req_addr | input | 36 | Physical address or I/O port |
| req_kind | input | 2 | Transaction kind |
| req_mtype | input | 3 | Caching type |
| req_len | input | 2 | Requested length code |
| req_be | input | 8 | Requested byte enables |
| bus_grant | input | 1 | Arbitration won |
| bus_addr | output | 33 | Shared address pins |
| bus_req | output | 5 | Shared request pins |
| bus_strobe | output | 1 | Address strobe, packet A only |
| bus_busy | output | 1 | Request phase in progress |
| req_done | output | 1 | Packet B cycle, phase complete |
| req_err | output | 1 | Request refused |

## Verification
Requests are sent with every legal caching type, so that the forced write-back line can be told apart from pass-through lengths and partial masks. Memory and I/O kinds are sent with high address bits set, which separates the port-number truncation from plain address slicing, and the all-ones address checks the top pin. Grants are held back for several cycles and a second offer is pushed in while a request waits, which shows that nothing starts early and the captured request is not overwritten. Illegal caching types and short write-back lengths are offered with the grant already high, to prove the refusal produces no bus activity.

// File: rtl/bre_pkg.sv
package bre_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PKA  = 2'd2,
    ST_PKB  = 2'd3
  } bre_state_e;

  localparam logic [2:0] MT_UC = 3'd0;
  localparam logic [2:0] MT_WC = 3'd1;
  localparam logic [2:0] MT_WT = 3'd4;
  localparam logic [2:0] MT_WP = 3'd5;
  localparam logic [2:0] MT_WB = 3'd6;

  localparam logic [1:0] LEN_LINE = 2'b11;
endpackage

// File: rtl/bre_attr.sv
module bre_attr
  import bre_pkg::*;
#(
  parameter int BE_W = 8
) (
  input  logic [2:0]      mtype,
  input  logic [1:0]      len_in,
  input  logic [BE_W-1:0] be_in,
  output logic [1:0]      len_out,
  output logic [BE_W-1:0] be_out,
  output logic            illegal
);
  always_comb begin
    len_out = len_in;
    be_out  = be_in;
    illegal = 1'b0;
    case (mtype)
      MT_WB: begin
        len_out = LEN_LINE;
        be_out  = '1;
        illegal = (len_in != LEN_LINE);
      end
      MT_UC, MT_WC, MT_WT, MT_WP: begin
        len_out = len_in;
        be_out  = be_in;
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/bre_ctrl.sv
module bre_ctrl
  import bre_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       illegal,
  input  logic       grant,
  output bre_state_e st,
  output logic       capture,
  output logic       err
);
  bre_state_e st_nxt;
  logic       err_nxt;

  always_comb begin
    st_nxt  = st;
    capture = 1'b0;
    err_nxt = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          if (illegal) begin
            err_nxt = 1'b1;
          end else begin
            capture = 1'b1;
            st_nxt  = ST_WAIT;
          end
        end
      end
      ST_WAIT: if (grant) st_nxt = ST_PKA;
      ST_PKA:  st_nxt = ST_PKB;
      ST_PKB:  st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      err <= 1'b0;
    end else begin
      st  <= st_nxt;
      err <= err_nxt;
    end
  end

  // R8: a refusal always answers an offer made one cycle earlier
  assert_err_follows_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid));
  // R7: packet A is only entered after the grant was sampled
  assert_grant_before_pkta_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PKA) |-> $past(grant));
  // R10: a pending request is never dropped without a grant
  assert_hold_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !grant) |=> (st == ST_WAIT));
endmodule

// File: rtl/bre_pack.sv
module bre_pack
  import bre_pkg::*;
#(
  parameter int PA_W    = 36,
  parameter int LO_BITS = 3,
  parameter int BE_W    = 8,
  parameter int IO_W    = 16,
  parameter int REQ_W   = 5,
  localparam int AP_W   = PA_W - LO_BITS
) (
  input  bre_state_e      st,
  input  logic [PA_W-1:0] addr,
  input  logic [1:0]      kind,
  input  logic [2:0]      mtype,
  input  logic [1:0]      len,
  input  logic [BE_W-1:0] be,
  output logic [AP_W-1:0] pin_addr,
  output logic [REQ_W-1:0] pin_req,
  output logic            strobe,
  output logic            busy,
  output logic            done
);
  logic [AP_W-1:0] io_mask;
  logic [AP_W-1:0] line_addr;

  for (genvar g = 0; g < AP_W; g++) begin : g_io_mask
    assign io_mask[g] = ((g + LO_BITS) < IO_W) ? 1'b1 : 1'b0;
  end

  assign line_addr = kind[1] ? (addr[PA_W-1:LO_BITS] & io_mask)
                             : addr[PA_W-1:LO_BITS];

  always_comb begin
    pin_addr = '0;
    pin_req  = '0;
    strobe   = 1'b0;
    busy     = 1'b0;
    done     = 1'b0;
    case (st)
      ST_PKA: begin
        pin_addr     = line_addr;
        pin_req[1:0] = kind;
        strobe       = 1'b1;
        busy         = 1'b1;
      end
      ST_PKB: begin
        pin_addr[2:0]      = mtype;
        pin_addr[3 +: BE_W] = be;
        pin_req[1:0]       = len;
        busy               = 1'b1;
        done               = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_req_encoder.sv
module bus_req_encoder
  import bre_pkg::*;
#(
  parameter int PA_W    = 36,
  parameter int LO_BITS = 3,
  parameter int BE_W    = 8,
  parameter int IO_W    = 16,
  parameter int REQ_W   = 5,
  localparam int AP_W   = PA_W - LO_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_mtype,
  input  logic [1:0]        req_len,
  input  logic [BE_W-1:0]   req_be,
  input  logic              bus_grant,
  output logic [AP_W-1:0]   bus_addr,
  output logic [REQ_W-1:0]  bus_req,
  output logic              bus_strobe,
  output logic              bus_busy,
  output logic              req_done,
  output logic              req_err
);
  bre_state_e      st;
  logic            capture;
  logic            illegal;
  logic [1:0]      eff_len;
  logic [BE_W-1:0] eff_be;

  logic [PA_W-1:0] h_addr;
  logic [1:0]      h_kind;
  logic [2:0]      h_mtype;
  logic [1:0]      h_len;
  logic [BE_W-1:0] h_be;

  bre_attr #(.BE_W(BE_W)) u_attr (
    .mtype  (req_mtype),
    .len_in (req_len),
    .be_in  (req_be),
    .len_out(eff_len),
    .be_out (eff_be),
    .illegal(illegal)
  );

  bre_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .illegal  (illegal),
    .grant    (bus_grant),
    .st       (st),
    .capture  (capture),
    .err      (req_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr  <= '0;
      h_kind  <= '0;
      h_mtype <= '0;
      h_len   <= '0;
      h_be    <= '0;
    end else if (capture) begin
      h_addr  <= req_addr;
      h_kind  <= req_kind;
      h_mtype <= req_mtype;
      h_len   <= eff_len;
      h_be    <= eff_be;
    end
  end

  bre_pack #(
    .PA_W(PA_W), .LO_BITS(LO_BITS), .BE_W(BE_W), .IO_W(IO_W), .REQ_W(REQ_W)
  ) u_pack (
    .st      (st),
    .addr    (h_addr),
    .kind    (h_kind),
    .mtype   (h_mtype),
    .len     (h_len),
    .be      (h_be),
    .pin_addr(bus_addr),
    .pin_req (bus_req),
    .strobe  (bus_strobe),
    .busy    (bus_busy),
    .done    (req_done)
  );

  // R3: packet B always follows the strobed packet A
  assert_b_after_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> (req_done && !bus_strobe));
  // R9: busy ends after packet B
  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !bus_busy);
  // R9: pins rest at zero outside the request phase
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (bus_addr == '0 && bus_req == '0));
  // R4: a write-back packet B always describes a full line
  assert_wb_full_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && h_mtype == MT_WB) |-> (bus_req[1:0] == LEN_LINE && bus_addr[3 +: BE_W] == '1));
endmodule

// File: tb/bus_req_encoder_bench.sv
module bus_req_encoder_bench;
  typedef struct {
    logic [32:0] addr;
    logic [4:0]  req;
    logic        strobe;
    logic        done;
    string       tag;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [35:0] req_addr;
  logic [1:0]  req_kind;
  logic [2:0]  req_mtype;
  logic [1:0]  req_len;
  logic [7:0]  req_be;
  logic        bus_grant;
  logic [32:0] bus_addr;
  logic [4:0]  bus_req;
  logic        bus_strobe, bus_busy, req_done, req_err;

  int total = 0;
  int bad = 0;
  bit mon_on = 0;
  bit finished = 0;
  beat_t exp_q[$];

  always #10 clk = ~clk;

  bus_req_encoder u_bus_req_encoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_mtype(req_mtype), .req_len(req_len), .req_be(req_be),
    .bus_grant(bus_grant), .bus_addr(bus_addr), .bus_req(bus_req),
    .bus_strobe(bus_strobe), .bus_busy(bus_busy), .req_done(req_done), .req_err(req_err)
  );

  // monitor: compares every busy cycle against the scoreboard, idle cycles against zero
  always @(negedge clk) begin
    if (mon_on) begin
      total++;
      if (bus_busy) begin
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R7 unexpected beat addr=%h req=%h expected none", bus_addr, bus_req);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          if (bus_addr !== e.addr || bus_req !== e.req || bus_strobe !== e.strobe || req_done !== e.done) begin
            bad++;
            $display("FAIL %s addr=%h req=%h stb=%b done=%b expected addr=%h req=%h stb=%b done=%b",
                     e.tag, bus_addr, bus_req, bus_strobe, req_done, e.addr, e.req, e.strobe, e.done);
          end
        end
      end else if (bus_addr !== '0 || bus_req !== '0 || bus_strobe || req_done) begin
        bad++;
        $display("FAIL R9 idle pins addr=%h req=%h stb=%b done=%b expected all zero",
                 bus_addr, bus_req, bus_strobe, req_done);
      end
    end
  end

  task automatic send(input logic [35:0] a, input logic [1:0] k, input logic [2:0] mt,
                      input logic [1:0] ln, input logic [7:0] be, input int gdly,
                      input bit intrude, input string tag);
    beat_t pa, pb;
    logic [32:0] la;
    logic [1:0]  el;
    logic [7:0]  eb;
    la = a[35:3];
    if (k[1]) la = la & 33'h0_0000_1FFF;
    if (mt == 3'd6) begin el = 2'b11; eb = 8'hFF; end
    else begin el = ln; eb = be; end
    pa.addr = la; pa.req = {3'b000, k}; pa.strobe = 1'b1; pa.done = 1'b0; pa.tag = {tag, " pktA"};
    pb.addr = {22'd0, eb, mt}; pb.req = {3'b000, el}; pb.strobe = 1'b0; pb.done = 1'b1;
    pb.tag = {tag, " pktB"};
    exp_q.push_back(pa);
    exp_q.push_back(pb);
    @(negedge clk);
    req_addr = a; req_kind = k; req_mtype = mt; req_len = ln; req_be = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      // R10: second offer while pending must be ignored
      req_addr = ~a; req_kind = ~k; req_mtype = 3'd0; req_len = 2'b00; req_be = 8'h01;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    repeat (gdly) @(negedge clk);
    bus_grant = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_grant = 1'b0;
    @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R7 %s beats left=%0d expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic refuse(input logic [2:0] mt, input logic [1:0] ln, input string tag);
    @(negedge clk);
    req_addr = 36'h1_2345_6788; req_kind = 2'b01; req_mtype = mt; req_len = ln; req_be = 8'hFF;
    req_valid = 1'b1; bus_grant = 1'b1;
    @(negedge clk);
    total++;
    if (req_err !== 1'b1) begin
      bad++;
      $display("FAIL R8 %s err=%b expected 1", tag, req_err);
    end
    req_valid = 1'b0;
    @(negedge clk);
    total++;
    if (req_err !== 1'b0) begin
      bad++;
      $display("FAIL R8 %s err second cycle=%b expected 0", tag, req_err);
    end
    repeat (3) @(negedge clk);   // monitor proves no packet appears
    bus_grant = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_mtype = '0;
    req_len = '0; req_be = '0; bus_grant = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;  // R1 reset state
    if (bus_addr !== '0 || bus_req !== '0 || bus_strobe || bus_busy || req_done || req_err) begin
      bad++;
      $display("FAIL R1 reset addr=%h req=%h stb=%b busy=%b done=%b err=%b expected zeros",
               bus_addr, bus_req, bus_strobe, bus_busy, req_done, req_err);
    end
    mon_on = 1'b1;
    send(36'h8_7654_3218, 2'b00, 3'd6, 2'b11, 8'h0F, 0, 0, "R2 R4 wb read");
    send(36'h0_0000_1005, 2'b01, 3'd0, 2'b00, 8'h30, 1, 0, "R5 uc write partial");
    send(36'h3_3333_3330, 2'b00, 3'd1, 2'b01, 8'hFF, 0, 0, "R5 wc 16B");
    send(36'h5_AAAA_5558, 2'b01, 3'd4, 2'b00, 8'h81, 2, 0, "R5 wt");
    send(36'h0_F0F0_F0F0, 2'b00, 3'd5, 2'b11, 8'hC3, 0, 0, "R5 wp line");
    send(36'hF_FFFF_ABCF, 2'b10, 3'd0, 2'b00, 8'h04, 0, 0, "R6 io read");
    send(36'h7_0000_FFF8, 2'b11, 3'd0, 2'b00, 8'h40, 1, 0, "R6 io write");
    send(36'h9_1111_2220, 2'b01, 3'd6, 2'b11, 8'h00, 4, 1, "R7 R10 delayed grant");
    send(36'hF_FFFF_FFFF, 2'b00, 3'd6, 2'b11, 8'hFF, 0, 0, "R2 max address");
    refuse(3'd6, 2'b00, "wb short");
    refuse(3'd6, 2'b01, "wb 16B");
    refuse(3'd2, 2'b11, "type 2");
    refuse(3'd7, 2'b00, "type 7");
    send(36'h2_4680_1358, 2'b01, 3'd0, 2'b00, 8'h01, 0, 0, "R8 recovers after refusal");
    mon_on = 1'b0;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule